// File: doc/BRIEF.md
# Plug-and-play card configuration controller

This block is the card-side control logic of a plug-and-play expansion card on a legacy 8-bit I/O bus. Host software writes an index to the address port and then reads or writes the data port. The block decodes the card-level indices 0x00 to 0x07 and keeps the card state (Wait for Key, Sleep, Isolation, Config), the card select number, the selected logical device and the upper bits of the programmable read-port address.

The initiation-key detector lives outside and delivers a one-cycle pulse. The serial identifier comparison also lives outside: one identifier bit arrives on an input, and the block answers an isolation read with a pattern chosen by that bit while it pulses a strobe that advances the outside comparator. Resource bytes come from an external source. The block exposes a byte pointer to that source, and the source answers with a valid flag and a byte. The block pops a byte by pulsing ready.

State encoding on `card_state`: 0 Wait for Key, 1 Sleep, 2 Isolation, 3 Config. An address-port write takes effect at the next clock edge, so a data access in the same cycle still uses the old index. `dp_rdata` is combinational from the current index, the state and the inputs.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset `card_state` is 0 (Wait for Key), `csn` is 0, `ldn` is 0, `rdport_addr` is 0x003, `res_ptr` is 0 and `dev_reset` is 0.
- R2: A `key_pulse` in Wait for Key sets the state to Sleep at the next edge; in any other state it has no effect. In Wait for Key every data-port write is ignored, `dp_rdata` reads 0xFF and neither `res_ready` nor `iso_cmp` pulses.
- R3: A data write to index 0x00 in Config loads the byte into read-port bits [9:2]; `rdport_addr` bits [1:0] always read 11. A read of index 0x00 returns 0xFF and changes nothing.
- R4: A write to index 0x02 in Sleep, Isolation or Config acts on each bit independently and leaves nothing stored. Bit0 pulses `dev_reset` high for exactly the next cycle and keeps the CSN. Bit1 moves the state to Wait for Key and keeps the CSN and the logical device. Bit2 clears the CSN to 0.
- R5: A write to index 0x03 in Sleep whose data equals the CSN moves the state to Isolation when the data is 0, or to Config otherwise. The same write sets `res_ptr` to 0. A mismatching value, or a wake in any other state, changes nothing.
- R6: In Config, a read of index 0x05 returns 0x01 when `res_valid` is high and 0x00 otherwise. A read of index 0x04 with `res_valid` high returns `res_data`, pulses `res_ready` in the same cycle and increments `res_ptr` at the edge. Without `res_valid` it returns 0xFF, `res_ready` stays low and `res_ptr` keeps its value.
- R7: A write to index 0x06 in Sleep, Isolation or Config sets the CSN. A read of index 0x06 in Config returns the CSN.
- R8: A write to index 0x07 in Config selects logical device `dp_wdata` when that value is below `NUM_LDN`; a larger value is ignored. A read of index 0x07 in Config returns the selection. With `NUM_LDN` = 1 the selection is always 0.
- R9: A read of index 0x01 in Isolation pulses `iso_cmp` in that cycle and returns 0x55 when `id_bit` is 1 or 0xAA when it is 0. In any other state the read returns 0xFF and `iso_cmp` stays low.
- R10: Writes to indices 0x00 and 0x07 are ignored outside Config. Indices 0x04 to 0x07 read 0xFF outside Config. Indices 0x02, 0x03 and every index above 0x07 always read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_pulse | input | 1 | One-cycle initiation-key detected |
| addr_wr | input | 1 | Address-port write strobe |
| addr_data | input | 8 | Register index written to the address port |
| dp_wr | input | 1 | Data-port write strobe |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wdata | input | 8 | Data-port write byte |
| dp_rdata | output | 8 | Data-port read byte |
| id_bit | input | 1 | Current identifier bit from the isolation comparator |
| iso_cmp | output | 1 | Strobe: an isolation read took place |
| res_valid | input | 1 | Resource byte available |
| res_data | input | 8 | Resource byte at `res_ptr` |
| res_ready | output | 1 | Resource byte consumed this cycle |
| res_ptr | output | PTR_W | Resource byte pointer |
| dev_reset | output | 1 | One-cycle logical-device reset |
| card_state | output | 2 | Card state |
| csn | output | 8 | Card select number |
| ldn | output | LDN_W | Selected logical device |
| rdport_addr | output | 10 | Read-port address |

## Verification
The bench builds two copies on the same stimulus. One has `NUM_LDN` = 3, so the logical-device field is two bits wide and the value 3 is both representable and out of range, which exercises the rejected select write. The other has `NUM_LDN` = 1, which selects the tied-off variant that must keep reading 0 after select writes. Both use the default `PTR_W` of 8; the pointer stays far below its wrap, so the wrap is not exercised.

// File: rtl/pnp_pkg.sv
package pnp_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } card_state_t;

  localparam logic [7:0] IX_RDPORT  = 8'h00;
  localparam logic [7:0] IX_ISOLATE = 8'h01;
  localparam logic [7:0] IX_CTRL    = 8'h02;
  localparam logic [7:0] IX_WAKE    = 8'h03;
  localparam logic [7:0] IX_RESDATA = 8'h04;
  localparam logic [7:0] IX_RESSTAT = 8'h05;
  localparam logic [7:0] IX_CSN     = 8'h06;
  localparam logic [7:0] IX_LDN     = 8'h07;

  localparam logic [7:0] RD_IDLE  = 8'hFF;
  localparam logic [7:0] ISO_ONE  = 8'h55;
  localparam logic [7:0] ISO_ZERO = 8'hAA;

  // Full read-port address from the stored upper byte.
  function automatic logic [9:0] rdport_of(input logic [7:0] hi);
    return {hi, 2'b11};
  endfunction

  // State reached by a matching wake write.
  function automatic card_state_t wake_target(input logic [7:0] d);
    return (d == 8'h00) ? ST_ISOLATE : ST_CONFIG;
  endfunction

  // Byte returned by an isolation read.
  function automatic logic [7:0] iso_reply(input logic b);
    return b ? ISO_ONE : ISO_ZERO;
  endfunction

endpackage

// File: rtl/pnp_state_fsm.sv
module pnp_state_fsm
  import pnp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_key,
  input  logic        ev_return,
  input  logic        ev_wake,
  input  logic [7:0]  wake_data,
  output card_state_t state
);

  card_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_KEY;
    end else if (ev_key) begin
      state_q <= ST_SLEEP;
    end else if (ev_return) begin
      state_q <= ST_WAIT_KEY;
    end else if (ev_wake) begin
      state_q <= wake_target(wake_data);
    end
  end

  assign state = state_q;

  assert_key_to_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_key |=> state_q == ST_SLEEP);

  assert_return_to_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_return |=> state_q == ST_WAIT_KEY);

  assert_wake_leaves_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake |=> (state_q == ST_ISOLATE || state_q == ST_CONFIG));

endmodule

// File: rtl/pnp_card_regs.sv
module pnp_card_regs
  import pnp_pkg::*;
#(
  parameter int NUM_LDN = 4,
  localparam int LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_setcsn,
  input  logic             ev_csnclr,
  input  logic             ev_rdport,
  input  logic             ev_setldn,
  input  logic [7:0]       wdata,
  output logic [7:0]       csn,
  output logic [LDN_W-1:0] ldn,
  output logic [9:0]       rdport
);

  logic [7:0] csn_q;
  logic [7:0] rp_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= 8'h00;
    end else if (ev_csnclr) begin
      csn_q <= 8'h00;
    end else if (ev_setcsn) begin
      csn_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_hi_q <= 8'h00;
    end else if (ev_rdport) begin
      rp_hi_q <= wdata;
    end
  end

  generate
    if (NUM_LDN > 1) begin : g_multi
      logic [LDN_W-1:0] ldn_q;
      logic             ldn_fits;

      assign ldn_fits = (int'(wdata) < NUM_LDN);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ldn_q <= '0;
        end else if (ev_setldn && ldn_fits) begin
          ldn_q <= wdata[LDN_W-1:0];
        end
      end

      assign ldn = ldn_q;

      assert_ldn_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ldn_q) < NUM_LDN);
    end else begin : g_single
      logic unused_ldn_wr;
      assign unused_ldn_wr = ev_setldn;
      assign ldn = '0;
    end
  endgenerate

  assign csn    = csn_q;
  assign rdport = rdport_of(rp_hi_q);

  assert_csn_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_csnclr |=> csn_q == 8'h00);

  assert_csn_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_setcsn && !ev_csnclr) |=> csn_q == $past(wdata));

endmodule

// File: rtl/pnp_res_port.sv
module pnp_res_port #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_rewind,
  input  logic             ev_pop,
  output logic [PTR_W-1:0] ptr
);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ev_rewind) begin
      ptr_q <= '0;
    end else if (ev_pop) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr = ptr_q;

  assert_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rewind |=> ptr_q == '0);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rewind && !ev_pop) |=> $stable(ptr_q));

endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_pkg::*;
#(
  parameter int NUM_LDN = 4,
  parameter int PTR_W   = 8,
  localparam int LDN_W  = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_pulse,
  input  logic             addr_wr,
  input  logic [7:0]       addr_data,
  input  logic             dp_wr,
  input  logic             dp_rd,
  input  logic [7:0]       dp_wdata,
  output logic [7:0]       dp_rdata,
  input  logic             id_bit,
  output logic             iso_cmp,
  input  logic             res_valid,
  input  logic [7:0]       res_data,
  output logic             res_ready,
  output logic [PTR_W-1:0] res_ptr,
  output logic             dev_reset,
  output logic [1:0]       card_state,
  output logic [7:0]       csn,
  output logic [LDN_W-1:0] ldn,
  output logic [9:0]       rdport_addr
);

  card_state_t state;
  logic [7:0]  idx_q;
  logic        dev_reset_q;

  // Named internal events.
  logic in_wait, in_sleep, in_iso, in_cfg;
  logic wr_live, wr_cfg;
  logic ev_key, ev_wake, ev_ctrl;
  logic ev_devrst, ev_return, ev_csnclr;
  logic ev_setcsn, ev_rdport, ev_setldn;
  logic ev_iso, ev_pop;

  assign in_wait  = (state == ST_WAIT_KEY);
  assign in_sleep = (state == ST_SLEEP);
  assign in_iso   = (state == ST_ISOLATE);
  assign in_cfg   = (state == ST_CONFIG);

  assign wr_live   = dp_wr && !in_wait;
  assign wr_cfg    = dp_wr && in_cfg;

  assign ev_key    = key_pulse && in_wait;
  assign ev_ctrl   = wr_live && (idx_q == IX_CTRL);
  assign ev_devrst = ev_ctrl && dp_wdata[0];
  assign ev_return = ev_ctrl && dp_wdata[1];
  assign ev_csnclr = ev_ctrl && dp_wdata[2];
  assign ev_wake   = wr_live && in_sleep && (idx_q == IX_WAKE) && (dp_wdata == csn);
  assign ev_setcsn = wr_live && (idx_q == IX_CSN);
  assign ev_rdport = wr_cfg && (idx_q == IX_RDPORT);
  assign ev_setldn = wr_cfg && (idx_q == IX_LDN);
  assign ev_iso    = dp_rd && in_iso && (idx_q == IX_ISOLATE);
  assign ev_pop    = dp_rd && in_cfg && (idx_q == IX_RESDATA) && res_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
    end else if (addr_wr) begin
      idx_q <= addr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_reset_q <= 1'b0;
    end else begin
      dev_reset_q <= ev_devrst;
    end
  end

  pnp_state_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_key    (ev_key),
    .ev_return (ev_return),
    .ev_wake   (ev_wake),
    .wake_data (dp_wdata),
    .state     (state)
  );

  pnp_card_regs #(.NUM_LDN(NUM_LDN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_setcsn (ev_setcsn),
    .ev_csnclr (ev_csnclr),
    .ev_rdport (ev_rdport),
    .ev_setldn (ev_setldn),
    .wdata     (dp_wdata),
    .csn       (csn),
    .ldn       (ldn),
    .rdport    (rdport_addr)
  );

  pnp_res_port #(.PTR_W(PTR_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_rewind (ev_wake),
    .ev_pop    (ev_pop),
    .ptr       (res_ptr)
  );

  // Read multiplexer.
  always_comb begin
    dp_rdata = RD_IDLE;
    if (idx_q == IX_ISOLATE) begin
      if (in_iso) dp_rdata = iso_reply(id_bit);
    end else if (in_cfg) begin
      case (idx_q)
        IX_RESDATA: if (res_valid) dp_rdata = res_data;
        IX_RESSTAT: dp_rdata = {7'b0, res_valid};
        IX_CSN:     dp_rdata = csn;
        IX_LDN:     dp_rdata = 8'(ldn);
        default:    dp_rdata = RD_IDLE;
      endcase
    end
  end

  assign iso_cmp    = ev_iso;
  assign res_ready  = ev_pop;
  assign dev_reset  = dev_reset_q;
  assign card_state = state;

  assert_quiet_in_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (card_state == 2'd0) |-> (!res_ready && !iso_cmp));

  assert_devrst_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_devrst |=> dev_reset);

  assert_devrst_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> !dev_reset || $past(ev_devrst));

  assert_pop_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> res_valid);

  assert_iso_only_isolate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iso_cmp |-> card_state == 2'd2);

endmodule

// File: tb/test_pnp_card_ctrl.sv
module test_pnp_card_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_pulse = 1'b0;
  logic       addr_wr = 1'b0;
  logic [7:0] addr_data = 8'h00;
  logic       dp_wr = 1'b0;
  logic       dp_rd = 1'b0;
  logic [7:0] dp_wdata = 8'h00;
  logic       id_bit = 1'b0;
  logic       res_valid = 1'b0;
  logic [7:0] res_data = 8'h00;

  logic [7:0] rdata_a, rdata_b;
  logic       iso_a, iso_b, ready_a, ready_b, devrst_a, devrst_b;
  logic [7:0] ptr_a, ptr_b;
  logic [1:0] state_a, state_b;
  logic [7:0] csn_a, csn_b;
  logic [1:0] ldn_a;
  logic       ldn_b;
  logic [9:0] rp_a, rp_b;

  always #10 clk = ~clk;   // 50 MHz

  pnp_card_ctrl #(.NUM_LDN(3)) i_pnp_card_ctrl (
    .clk(clk), .rst_n(rst_n), .key_pulse(key_pulse), .addr_wr(addr_wr),
    .addr_data(addr_data), .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wdata(dp_wdata),
    .dp_rdata(rdata_a), .id_bit(id_bit), .iso_cmp(iso_a), .res_valid(res_valid),
    .res_data(res_data), .res_ready(ready_a), .res_ptr(ptr_a), .dev_reset(devrst_a),
    .card_state(state_a), .csn(csn_a), .ldn(ldn_a), .rdport_addr(rp_a)
  );

  pnp_card_ctrl #(.NUM_LDN(1)) i_pnp_card_ctrl_single (
    .clk(clk), .rst_n(rst_n), .key_pulse(key_pulse), .addr_wr(addr_wr),
    .addr_data(addr_data), .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wdata(dp_wdata),
    .dp_rdata(rdata_b), .id_bit(id_bit), .iso_cmp(iso_b), .res_valid(res_valid),
    .res_data(res_data), .res_ready(ready_b), .res_ptr(ptr_b), .dev_reset(devrst_b),
    .card_state(state_b), .csn(csn_b), .ldn(ldn_b), .rdport_addr(rp_b)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Behavioural reference state.
  int m_state = 0, m_csn = 0, m_ldn = 0, m_rphi = 0, m_ptr = 0, m_devrst = 0, m_idx = 0;
  int cap_rdata, cap_rdata1, cap_iso, cap_ready;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cmp_regs();
    chk("R5", "state", int'(state_a), m_state);
    chk("R7", "csn", int'(csn_a), m_csn);
    chk("R8", "ldn", int'(ldn_a), m_ldn);
    chk("R8", "ldn single", int'(ldn_b), 0);
    chk("R3", "rdport", int'(rp_a), m_rphi * 4 + 3);
    chk("R6", "res_ptr", int'(ptr_a), m_ptr);
    chk("R4", "dev_reset", int'(devrst_a), m_devrst);
    chk("R5", "state single", int'(state_b), m_state);
    chk("R7", "csn single", int'(csn_b), m_csn);
  endtask

  task automatic step(input bit k, input bit aw, input int ad,
                      input bit w, input bit r, input int wd);
    int erd, erd1, eiso, epop;
    int ns, ncsn, nldn, nrp, nptr, ndev;
    @(negedge clk);
    cmp_regs();
    key_pulse = k; addr_wr = aw; addr_data = 8'(ad);
    dp_wr = w; dp_rd = r; dp_wdata = 8'(wd);
    res_data = 8'((m_ptr * 37 + 5) % 256);
    #2;
    erd = 255; eiso = 0; epop = 0;
    if (m_state != 0) begin
      if (m_idx == 1) begin
        if (m_state == 2) begin
          erd = id_bit ? 'h55 : 'hAA;
          eiso = r;
        end
      end else if (m_state == 3) begin
        if (m_idx == 4 && res_valid) begin erd = int'(res_data); epop = r; end
        if (m_idx == 5) erd = res_valid ? 1 : 0;
        if (m_idx == 6) erd = m_csn;
        if (m_idx == 7) erd = m_ldn;
      end
    end
    erd1 = (m_state == 3 && m_idx == 7) ? 0 : erd;
    cap_rdata = int'(rdata_a); cap_rdata1 = int'(rdata_b);
    cap_iso = int'(iso_a); cap_ready = int'(ready_a);
    chk("R10", "dp_rdata", cap_rdata, erd);
    chk("R8", "dp_rdata single", cap_rdata1, erd1);
    chk("R9", "iso_cmp", cap_iso, eiso);
    chk("R6", "res_ready", cap_ready, epop);
    chk("R9", "iso_cmp single", int'(iso_b), eiso);
    chk("R6", "res_ready single", int'(ready_b), epop);
    @(posedge clk);
    ns = m_state; ncsn = m_csn; nldn = m_ldn; nrp = m_rphi; nptr = m_ptr; ndev = 0;
    if (m_state == 0) begin
      if (k) ns = 1;
    end else begin
      if (w) begin
        case (m_idx)
          0: if (m_state == 3) nrp = wd;
          2: begin
               ndev = wd & 1;
               if ((wd & 4) != 0) ncsn = 0;
               if ((wd & 2) != 0) ns = 0;
             end
          3: if (m_state == 1 && wd == m_csn) begin
               ns = (wd == 0) ? 2 : 3;
               nptr = 0;
             end
          6: ncsn = wd;
          7: if (m_state == 3 && wd < 3) nldn = wd;
          default: ;
        endcase
      end
      if (epop == 1) nptr = (m_ptr + 1) % 256;
    end
    if (aw) m_idx = ad;
    m_state = ns; m_csn = ncsn; m_ldn = nldn; m_rphi = nrp; m_ptr = nptr; m_devrst = ndev;
  endtask

  task automatic idle();            step(0, 0, 0, 0, 0, 0); endtask
  task automatic key();             step(1, 0, 0, 0, 0, 0); endtask
  task automatic sel(input int i);  step(0, 1, i, 0, 0, 0); endtask
  task automatic wr(input int d);   step(0, 0, 0, 1, 0, d); endtask
  task automatic rd();              step(0, 0, 0, 0, 1, 0); endtask
  task automatic put(input int i, input int d); sel(i); wr(d); endtask
  task automatic get(input int i);  sel(i); rd(); endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "reset state", int'(state_a), 0);
    chk("R1", "reset csn", int'(csn_a), 0);
    chk("R1", "reset ldn", int'(ldn_a), 0);
    chk("R1", "reset rdport", int'(rp_a), 'h003);
    chk("R1", "reset ptr", int'(ptr_a), 0);
    chk("R1", "reset dev_reset", int'(devrst_a), 0);
    rst_n = 1'b1;
    idle();

    // R2: accesses ignored in Wait for Key
    res_valid = 1'b1;
    put(6, 'h5A);
    #1 chk("R2", "csn untouched in wait", int'(csn_a), 0);
    get(5);
    chk("R2", "read in wait", cap_rdata, 'hFF);
    get(4);
    chk("R2", "no pop in wait", cap_ready, 0);
    key();
    #1 chk("R2", "key to sleep", int'(state_a), 1);
    key();
    #1 chk("R2", "key ignored in sleep", int'(state_a), 1);

    // R5: wake 0 to isolation; R9 isolation reads
    get(1);
    chk("R9", "isolation read in sleep", cap_rdata, 'hFF);
    put(3, 0);
    #1 chk("R5", "wake 0 to isolation", int'(state_a), 2);
    id_bit = 1'b1;
    get(1);
    chk("R9", "iso reply one", cap_rdata, 'h55);
    chk("R9", "iso strobe", cap_iso, 1);
    id_bit = 1'b0;
    rd();
    chk("R9", "iso reply zero", cap_rdata, 'hAA);

    // R10: config-only writes ignored in isolation
    put(0, 'h44);
    #1 chk("R10", "rdport write outside config", int'(rp_a), 'h003);
    put(7, 1);
    #1 chk("R10", "ldn write outside config", int'(ldn_a), 0);
    put(3, 0);
    #1 chk("R5", "wake ignored in isolation", int'(state_a), 2);

    // R7: CSN set in isolation; R4 return keeps CSN
    put(6, 3);
    #1 chk("R7", "csn set in isolation", int'(csn_a), 3);
    put(2, 2);
    #1 chk("R4", "return to wait", int'(state_a), 0);
    chk("R4", "csn kept on return", int'(csn_a), 3);
    key();
    put(3, 2);
    #1 chk("R5", "wake mismatch stays", int'(state_a), 1);
    wr(3);
    #1 chk("R5", "wake match to config", int'(state_a), 3);

    // R3: read-port address
    put(0, 'h8B);
    #1 chk("R3", "rdport loaded", int'(rp_a), 'h22F);
    rd();
    chk("R3", "read of index 0", cap_rdata, 'hFF);

    // R6: resource bytes
    res_valid = 1'b0;
    get(5);
    chk("R6", "status not ready", cap_rdata, 0);
    res_valid = 1'b1;
    rd();
    chk("R6", "status ready", cap_rdata, 1);
    get(4);
    chk("R6", "first byte", cap_rdata, 5);
    chk("R6", "pop strobe", cap_ready, 1);
    rd();
    chk("R6", "second byte", cap_rdata, 42);
    rd();
    #1 chk("R6", "pointer advanced", int'(ptr_a), 3);
    res_valid = 1'b0;
    rd();
    chk("R6", "no byte read", cap_rdata, 'hFF);
    chk("R6", "no pop without valid", cap_ready, 0);
    #1 chk("R6", "pointer held", int'(ptr_a), 3);
    res_valid = 1'b1;

    // R8: logical device select
    put(7, 2);
    #1 chk("R8", "ldn set", int'(ldn_a), 2);
    wr(3);
    #1 chk("R8", "ldn out of range ignored", int'(ldn_a), 2);
    rd();
    chk("R8", "ldn read", cap_rdata, 2);
    chk("R8", "single ldn read", cap_rdata1, 0);

    // R7 / R10 reads in config
    get(6);
    chk("R7", "csn read", cap_rdata, 3);
    get(2);
    chk("R10", "ctrl reads ff", cap_rdata, 'hFF);
    get(3);
    chk("R10", "wake reads ff", cap_rdata, 'hFF);
    get('h09);
    chk("R10", "undefined index", cap_rdata, 'hFF);

    // R4: control bits
    put(2, 1);
    #1 chk("R4", "dev_reset pulse", int'(devrst_a), 1);
    chk("R4", "csn kept on dev reset", int'(csn_a), 3);
    idle();
    #1 chk("R4", "dev_reset single cycle", int'(devrst_a), 0);
    put(2, 4);
    #1 chk("R4", "csn cleared", int'(csn_a), 0);
    chk("R4", "stay config on csn clear", int'(state_a), 3);
    put(6, 9);
    put(2, 7);
    #1 chk("R4", "all bits: wait", int'(state_a), 0);
    chk("R4", "all bits: csn 0", int'(csn_a), 0);
    chk("R4", "all bits: dev_reset", int'(devrst_a), 1);
    chk("R4", "ldn kept", int'(ldn_a), 2);

    // R5: matching wake rewinds pointer
    key();
    put(6, 7);
    put(3, 7);
    #1 chk("R5", "pointer rewound", int'(ptr_a), 0);
    chk("R5", "nonzero wake to config", int'(state_a), 3);
    get(4);
    chk("R6", "byte after rewind", cap_rdata, 5);
    idle();
    idle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule